// File: doc/BRIEF.md
# Unlock-Command Flash Operation Sequencer

This block sits between a host and a 16-bit parallel NOR flash that takes its commands as short series of bus writes with an unlock prefix. The host asks for one high-level operation at a time: reset, identifier read, sector erase, chip erase, word program, or the three operations that enter, use and leave a shortened programming mode. The block turns each operation into the right ordered series of writes and reads on a synchronous, word-addressed bus master port, and then returns one response with a status code and a data word.

For erase and program, the block watches the flash for completion. It reads the target word twice in a row and treats the operation as still running while the two reads differ, because a status bit toggles on each read while the flash is busy. If the toggle is still present after a set number of read pairs, the block writes the reset command and reports a timeout. After a program completes, it reads the word once more and reports a verify error if the word does not hold the requested value. The block keeps track of whether the flash is in the shortened programming mode. It refuses any operation that does not fit the current mode, and such a refusal makes no bus traffic.

Top module: `nor_flash_sequencer`

## Requirements
- R1: Reset state and bus master port. After reset, req_ready is 1, rsp_valid is 0, bus_req is 0 and bypass_on is 0. Once bus_req is raised, bus_we, bus_addr and bus_wdata stay unchanged until the cycle in which bus_ack is sampled high. bus_rdata is captured in that same cycle.
- R2: Request and response handshake. A request is accepted only on a cycle where req_valid and req_ready are both 1. req_ready is 0 in the cycle after acceptance. req_ready returns to 1 in the same cycle as rsp_valid. rsp_valid is high for exactly one cycle. The rsp_status codes are: 0 = ok, 1 = timeout, 2 = verify error, 3 = mode refusal.
- R3: Identifier read (op 1). The block writes 0xAA to word 0x5555, then 0x55 to word 0x2AAA, then 0x90 to 0x5555. It then reads the target word and writes 0xF0 to the target. rsp_rdata returns the word that was read.
- R4: Sector erase (op 2). The block issues the unlock pair, then 0x80 to 0x5555, then the unlock pair again, then 0x30 to the target. After that it polls as described in R7.
- R5: Chip erase (op 3). The block issues the unlock pair, then 0x80 to 0x5555, then the unlock pair again, then 0x10 to 0x5555. After that it polls the target as described in R7.
- R6: Word program (op 4). The block issues the unlock pair, then 0xA0 to 0x5555, then the request data to the target. After that it polls (R7) and verifies (R9).
- R7: Completion polling. The block reads the target in pairs of back-to-back reads. The operation is complete at the first pair whose two words are equal, and rsp_rdata then returns that word. Each pair that differs is followed by a further pair.
- R8: Timeout. If MAX_POLLS pairs in a row differ, the block makes no more reads. It writes 0xF0 to the target and responds with status 1.
- R9: Verify. After a program completes, the block reads the target once more. If that word differs from the request data, the status is 2. rsp_rdata returns the word read back.
- R10: Bypass entry (op 5). The block issues the unlock pair, then 0x20 to 0x5555. bypass_on becomes 1 in the cycle of the ok response.
- R11: Bypass program (op 6). The block writes 0xA0 to the target, then the request data to the target, with no unlock pair. After that it polls (R7) and verifies (R9).
- R12: Bypass exit (op 7). The block writes 0x90 to the target, then 0x00 to the target. bypass_on becomes 0 in the cycle of the ok response.
- R13: Mode gating. The block refuses with status 3, and makes no bus cycle, in three cases: op 6 or op 7 while bypass_on is 0, op 5 while bypass_on is 1, and ops 1 to 4 while bypass_on is 1.
- R14: Reset (op 0). The block makes a single write of 0xF0 to the target address, then responds with status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_op | input | 3 | Operation code (0 to 7, see requirements) |
| req_addr | input | ADDR_W | Target word address |
| req_data | input | DATA_W | Data word for program operations |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 timeout, 2 verify error, 3 mode refusal |
| rsp_rdata | output | DATA_W | Identifier, final poll word or read-back word |
| bypass_on | output | 1 | Flash is in the shortened programming mode |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | ADDR_W | Bus word address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_ack | input | 1 | Bus cycle complete |
| bus_rdata | input | DATA_W | Bus read data, valid with bus_ack |

## Verification
The flash model in the bench toggles a status bit for a chosen number of reads after each program or erase. This lets polling be tried with zero, short and endless busy spans: zero proves that one equal pair ends the poll, a short span proves that differing pairs are retried, and an endless span separates a real completion from the timeout path with its reset write. Programs that clear bits are distinguished from programs that need a 0-to-1 change, and only the second kind must give a verify error. Each operation is run both inside and outside the bypass mode, so that a correct sequence, a refused request with no bus traffic, and an unlock prefix that has been left out can be told apart.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [2:0] {
    OP_RESET        = 3'd0,
    OP_READ_ID      = 3'd1,
    OP_SECTOR_ERASE = 3'd2,
    OP_CHIP_ERASE   = 3'd3,
    OP_PROGRAM      = 3'd4,
    OP_BYP_ENTER    = 3'd5,
    OP_BYP_PROGRAM  = 3'd6,
    OP_BYP_EXIT     = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    STS_OK      = 2'd0,
    STS_TIMEOUT = 2'd1,
    STS_VERIFY  = 2'd2,
    STS_MODE    = 2'd3
  } status_e;

  typedef enum logic [2:0] {
    K_WRITE, K_READ_KEEP, K_POLL, K_VERIFY, K_END
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic        use_target;
    logic        use_reqdata;
    logic [15:0] addr;
    logic [7:0]  cmd;
  } step_t;

  localparam int STEP_IDX_W = 4;

  localparam logic [15:0] ADDR_KEY_A = 16'h5555;
  localparam logic [15:0] ADDR_KEY_B = 16'h2AAA;

  localparam logic [7:0] CMD_KEY_A   = 8'hAA;
  localparam logic [7:0] CMD_KEY_B   = 8'h55;
  localparam logic [7:0] CMD_ERASE   = 8'h80;
  localparam logic [7:0] CMD_SECTOR  = 8'h30;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_BYPASS  = 8'h20;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_BYP_OUT = 8'h00;
  localparam logic [7:0] CMD_RESET   = 8'hF0;

  function automatic step_t s_fixed(logic [15:0] a, logic [7:0] c);
    return '{kind: K_WRITE, use_target: 1'b0, use_reqdata: 1'b0, addr: a, cmd: c};
  endfunction

  function automatic step_t s_target(logic [7:0] c);
    return '{kind: K_WRITE, use_target: 1'b1, use_reqdata: 1'b0, addr: 16'h0, cmd: c};
  endfunction

  function automatic step_t s_data();
    return '{kind: K_WRITE, use_target: 1'b1, use_reqdata: 1'b1, addr: 16'h0, cmd: 8'h0};
  endfunction

  function automatic step_t s_read(kind_e k);
    return '{kind: k, use_target: 1'b1, use_reqdata: 1'b0, addr: 16'h0, cmd: 8'h0};
  endfunction

  // Unlock pair occupies idx 0/1 for any op that needs it.
  function automatic step_t s_key(logic [STEP_IDX_W-1:0] i);
    return (i[0] == 1'b0) ? s_fixed(ADDR_KEY_A, CMD_KEY_A) : s_fixed(ADDR_KEY_B, CMD_KEY_B);
  endfunction

  function automatic step_t step_lookup(op_e op, logic [STEP_IDX_W-1:0] idx);
    step_t s;
    s = s_read(K_END);
    case (op)
      OP_RESET: if (idx == 0) s = s_target(CMD_RESET);
      OP_READ_ID:
        case (idx)
          0, 1: s = s_key(idx);
          2: s = s_fixed(ADDR_KEY_A, CMD_IDENT);
          3: s = s_read(K_READ_KEEP);
          4: s = s_target(CMD_RESET);
          default: s = s_read(K_END);
        endcase
      OP_SECTOR_ERASE, OP_CHIP_ERASE:
        case (idx)
          0, 1, 3, 4: s = s_key(idx + ((idx > 2) ? 4'd1 : 4'd0));
          2: s = s_fixed(ADDR_KEY_A, CMD_ERASE);
          5: s = (op == OP_SECTOR_ERASE) ? s_target(CMD_SECTOR)
                                         : s_fixed(ADDR_KEY_A, CMD_CHIP);
          6: s = s_read(K_POLL);
          default: s = s_read(K_END);
        endcase
      OP_PROGRAM:
        case (idx)
          0, 1: s = s_key(idx);
          2: s = s_fixed(ADDR_KEY_A, CMD_PROG);
          3: s = s_data();
          4: s = s_read(K_POLL);
          5: s = s_read(K_VERIFY);
          default: s = s_read(K_END);
        endcase
      OP_BYP_ENTER:
        case (idx)
          0, 1: s = s_key(idx);
          2: s = s_fixed(ADDR_KEY_A, CMD_BYPASS);
          default: s = s_read(K_END);
        endcase
      OP_BYP_PROGRAM:
        case (idx)
          0: s = s_target(CMD_PROG);
          1: s = s_data();
          2: s = s_read(K_POLL);
          3: s = s_read(K_VERIFY);
          default: s = s_read(K_END);
        endcase
      OP_BYP_EXIT:
        case (idx)
          0: s = s_target(CMD_IDENT);
          1: s = s_target(CMD_BYP_OUT);
          default: s = s_read(K_END);
        endcase
      default: s = s_read(K_END);
    endcase
    return s;
  endfunction

  function automatic logic op_allowed(op_e op, logic byp);
    case (op)
      OP_RESET:                    return 1'b1;
      OP_BYP_PROGRAM, OP_BYP_EXIT: return byp;
      default:                     return !byp;
    endcase
  endfunction

endpackage

// File: rtl/fseq_step_rom.sv
module fseq_step_rom
  import fseq_pkg::*;
(
  input  op_e                   op,
  input  logic [STEP_IDX_W-1:0] idx,
  output step_t                 step
);
  always_comb step = step_lookup(op, idx);
endmodule

// File: rtl/fseq_bus_master.sv
module fseq_bus_master #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      if (bus_req) begin
        if (bus_ack) begin
          bus_req <= 1'b0;
          done    <= 1'b1;
          rdata   <= bus_rdata;
        end
      end else if (go) begin
        bus_req   <= 1'b1;
        bus_we    <= we;
        bus_addr  <= addr;
        bus_wdata <= wdata;
      end
    end
  end
endmodule

// File: rtl/fseq_poll_judge.sv
module fseq_poll_judge #(
  parameter int DATA_W    = 16,
  parameter int MAX_POLLS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              sample,
  input  logic [DATA_W-1:0] rd,
  output logic              second,
  output logic              match,
  output logic              exhausted
);
  localparam int CNT_W = $clog2(MAX_POLLS + 1);

  logic [DATA_W-1:0] first_q;
  logic              phase_q;
  logic [CNT_W-1:0]  pairs_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      first_q <= '0;
      phase_q <= 1'b0;
      pairs_q <= '0;
    end else if (sample) begin
      if (!phase_q) begin
        first_q <= rd;
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        if (rd != first_q) pairs_q <= pairs_q + 1'b1;
      end
    end
  end

  assign second    = phase_q;
  assign match     = (rd == first_q);
  assign exhausted = (pairs_q == CNT_W'(MAX_POLLS - 1));
endmodule

// File: rtl/nor_flash_sequencer.sv
module nor_flash_sequencer
  import fseq_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int MAX_POLLS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bypass_on,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  typedef enum logic [2:0] {
    FS_IDLE, FS_STEP, FS_WAIT, FS_ABORT, FS_ABWAIT, FS_RESP
  } fsm_e;

  fsm_e                  state;
  op_e                   op_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [DATA_W-1:0]     data_q;
  logic [STEP_IDX_W-1:0] idx_q;
  status_e               status_q;
  logic [DATA_W-1:0]     keep_q;

  step_t                 step;
  logic                  m_go, m_we, m_done;
  logic [ADDR_W-1:0]     m_addr;
  logic [DATA_W-1:0]     m_wdata, m_rdata;
  logic                  p_sample, p_second, p_match, p_exhausted;

  fseq_step_rom u_rom (
    .op   (op_q),
    .idx  (idx_q),
    .step (step)
  );

  always_comb begin
    m_go    = (state == FS_STEP && step.kind != K_END) || (state == FS_ABORT);
    m_we    = (state == FS_ABORT) || (step.kind == K_WRITE);
    m_addr  = ((state == FS_ABORT) || step.use_target) ? addr_q : ADDR_W'(step.addr);
    if (state == FS_ABORT)     m_wdata = DATA_W'(CMD_RESET);
    else if (step.use_reqdata) m_wdata = data_q;
    else                       m_wdata = DATA_W'(step.cmd);
  end

  fseq_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_master (
    .clk       (clk),
    .rst       (rst),
    .go        (m_go),
    .we        (m_we),
    .addr      (m_addr),
    .wdata     (m_wdata),
    .done      (m_done),
    .rdata     (m_rdata),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata)
  );

  assign p_sample = (state == FS_WAIT) && m_done && (step.kind == K_POLL);

  fseq_poll_judge #(.DATA_W(DATA_W), .MAX_POLLS(MAX_POLLS)) u_judge (
    .clk       (clk),
    .rst       (rst),
    .clear     (state == FS_IDLE),
    .sample    (p_sample),
    .rd        (m_rdata),
    .second    (p_second),
    .match     (p_match),
    .exhausted (p_exhausted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= FS_IDLE;
      op_q       <= OP_RESET;
      addr_q     <= '0;
      data_q     <= '0;
      idx_q      <= '0;
      status_q   <= STS_OK;
      keep_q     <= '0;
      req_ready  <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_status <= 2'd0;
      rsp_rdata  <= '0;
      bypass_on  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        FS_IDLE: if (req_valid) begin
          req_ready <= 1'b0;
          op_q      <= op_e'(req_op);
          addr_q    <= req_addr;
          data_q    <= req_data;
          idx_q     <= '0;
          keep_q    <= '0;
          if (op_allowed(op_e'(req_op), bypass_on)) begin
            status_q <= STS_OK;
            state    <= FS_STEP;
          end else begin
            status_q <= STS_MODE;
            state    <= FS_RESP;
          end
        end
        FS_STEP: state <= (step.kind == K_END) ? FS_RESP : FS_WAIT;
        FS_WAIT: if (m_done) begin
          state <= FS_STEP;
          case (step.kind)
            K_WRITE: idx_q <= idx_q + 1'b1;
            K_READ_KEEP: begin
              keep_q <= m_rdata;
              idx_q  <= idx_q + 1'b1;
            end
            K_POLL: if (p_second) begin
              if (p_match) begin
                keep_q <= m_rdata;
                idx_q  <= idx_q + 1'b1;
              end else if (p_exhausted) begin
                status_q <= STS_TIMEOUT;
                state    <= FS_ABORT;
              end
            end
            K_VERIFY: begin
              keep_q <= m_rdata;
              if (m_rdata != data_q) status_q <= STS_VERIFY;
              idx_q <= idx_q + 1'b1;
            end
            default: idx_q <= idx_q;
          endcase
        end
        FS_ABORT:  state <= FS_ABWAIT;
        FS_ABWAIT: if (m_done) state <= FS_RESP;
        FS_RESP: begin
          rsp_valid  <= 1'b1;
          rsp_status <= status_q;
          rsp_rdata  <= keep_q;
          req_ready  <= 1'b1;
          if (status_q == STS_OK && op_q == OP_BYP_ENTER) bypass_on <= 1'b1;
          if (status_q == STS_OK && op_q == OP_BYP_EXIT)  bypass_on <= 1'b0;
          state <= FS_IDLE;
        end
        default: state <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [1:0]        rsp_status,
  input logic              bypass_on,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack
);
  assert_bus_hold_R1: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

  assert_idle_no_bus_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !bus_req);

  assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);

  assert_rsp_single_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_rsp_with_ready_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);

  assert_enter_on_ok_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(bypass_on) |-> rsp_valid && rsp_status == 2'd0);

  assert_exit_on_ok_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(bypass_on) |-> rsp_valid && rsp_status == 2'd0);
endmodule

bind nor_flash_sequencer fseq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .bypass_on  (bypass_on),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_ack    (bus_ack)
);

// File: tb/nor_flash_sequencer_tb.sv
`timescale 1ns/1ps
module nor_flash_sequencer_tb;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int MP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          rsp_valid, bypass_on;
  logic [1:0]    rsp_status;
  logic [DW-1:0] rsp_rdata;
  logic          bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_ack = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  nor_flash_sequencer #(.ADDR_W(AW), .DATA_W(DW), .MAX_POLLS(MP)) u_dut (.*);

  int total = 0, fails = 0;

  // ---------------- flash model ----------------
  logic [DW-1:0] mem [int unsigned];
  logic [AW-1:0] log_a [0:255];
  logic [DW-1:0] log_d [0:255];
  int log_n = 0, reads_n = 0, busy_left = 0, busy_len = 0;
  logic tog = 1'b0, prog_arm = 1'b0, erase_arm = 1'b0, id_mode = 1'b0;
  logic [DW-1:0] last_wd = '0;
  logic [AW-1:0] last_wa = '0;

  function automatic logic [DW-1:0] mem_rd(logic [AW-1:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'hFFFF;
  endfunction

  always @(posedge clk) begin
    if (rst) bus_ack <= 1'b0;
    else if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_we) begin
        if (log_n < 256) begin log_a[log_n] = bus_addr; log_d[log_n] = bus_wdata; end
        log_n++;
        if (prog_arm) begin
          mem[int'(bus_addr)] = mem_rd(bus_addr) & bus_wdata;
          prog_arm = 1'b0; busy_left = busy_len;
        end else if (bus_wdata == 16'h00F0) begin
          busy_left = 0; id_mode = 1'b0; erase_arm = 1'b0;
        end else if (bus_wdata == 16'h00A0) prog_arm = 1'b1;
        else if (bus_wdata == 16'h0080) erase_arm = 1'b1;
        else if (erase_arm && (bus_wdata == 16'h0030 || bus_wdata == 16'h0010)) begin
          mem.delete(); erase_arm = 1'b0; busy_left = busy_len;
        end else if (bus_wdata == 16'h0090 && last_wd == 16'h0055 && last_wa == AW'(16'h2AAA))
          id_mode = 1'b1;
        last_wd = bus_wdata; last_wa = bus_addr;
      end else begin
        reads_n++;
        if (busy_left > 0) begin
          busy_left--; tog = ~tog;
          bus_rdata <= {9'b0, tog, 6'b0};
        end else if (id_mode) bus_rdata <= 16'hC200 | {8'h00, bus_addr[7:0]};
        else bus_rdata <= mem_rd(bus_addr);
      end
    end else bus_ack <= 1'b0;
  end

  // ---------------- helpers ----------------
  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [1:0]    got_sts;
  logic [DW-1:0] got_data;
  int            base_w, base_r;

  task automatic do_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    base_w = log_n; base_r = reads_n;
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
    while (!rsp_valid) @(negedge clk);
    got_sts = rsp_status; got_data = rsp_rdata;
    chk(req_ready == 1'b1, "R2 ready with response", req_ready, 1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 single-cycle response", rsp_valid, 0);
  endtask

  task automatic chk_wr(input int i, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    chk(log_a[base_w + i] == a && log_d[base_w + i] == d, tag,
        int'({log_a[base_w + i], log_d[base_w + i]}), int'({a, d}));
  endtask

  task automatic chk_key(input int i, input string tag);
    chk_wr(i, AW'(16'h5555), 16'h00AA, tag);
    chk_wr(i + 1, AW'(16'h2AAA), 16'h0055, tag);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 reset handshake", {req_ready, rsp_valid}, 2);
    chk(bus_req == 1'b0 && bypass_on == 1'b0, "R1 reset bus/mode", {bus_req, bypass_on}, 0);
  endtask

  task automatic t_reset_op();
    do_op(3'd0, 22'h000123, '0);
    chk(log_n - base_w == 1 && reads_n == base_r, "R14 one write", log_n - base_w, 1);
    chk_wr(0, 22'h000123, 16'h00F0, "R14 reset write");
    chk(got_sts == 2'd0, "R14 status", got_sts, 0);
  endtask

  task automatic t_read_id();
    do_op(3'd1, 22'h000003, '0);
    chk(log_n - base_w == 4 && reads_n - base_r == 1, "R3 cycle count", log_n - base_w, 4);
    chk_key(0, "R3 unlock");
    chk_wr(2, AW'(16'h5555), 16'h0090, "R3 ident cmd");
    chk_wr(3, 22'h000003, 16'h00F0, "R3 exit write");
    chk(got_data == 16'hC203 && got_sts == 2'd0, "R3 id data", got_data, 16'hC203);
  endtask

  task automatic t_sector_erase();
    mem[32'h1234] = 16'h0000;
    busy_len = 3;
    do_op(3'd2, 22'h001234, '0);
    chk(log_n - base_w == 6, "R4 write count", log_n - base_w, 6);
    chk_key(0, "R4 unlock 1");
    chk_wr(2, AW'(16'h5555), 16'h0080, "R4 erase setup");
    chk_key(3, "R4 unlock 2");
    chk_wr(5, 22'h001234, 16'h0030, "R4 sector cmd");
    chk(reads_n - base_r == 6, "R7 poll pairs retried", reads_n - base_r, 6);
    chk(got_sts == 2'd0 && got_data == 16'hFFFF, "R7 final word", got_data, 16'hFFFF);
  endtask

  task automatic t_chip_erase();
    busy_len = 0;
    do_op(3'd3, 22'h000777, '0);
    chk(log_n - base_w == 6, "R5 write count", log_n - base_w, 6);
    chk_wr(2, AW'(16'h5555), 16'h0080, "R5 erase setup");
    chk_key(3, "R5 unlock 2");
    chk_wr(5, AW'(16'h5555), 16'h0010, "R5 chip cmd");
    chk(reads_n - base_r == 2 && got_sts == 2'd0, "R7 single equal pair", reads_n - base_r, 2);
  endtask

  task automatic t_program();
    busy_len = 2;
    do_op(3'd4, 22'h000040, 16'h5555);
    chk(log_n - base_w == 4, "R6 write count", log_n - base_w, 4);
    chk_key(0, "R6 unlock");
    chk_wr(2, AW'(16'h5555), 16'h00A0, "R6 program cmd");
    chk_wr(3, 22'h000040, 16'h5555, "R6 data write");
    chk(reads_n - base_r == 5, "R9 poll plus verify read", reads_n - base_r, 5);
    chk(got_sts == 2'd0 && got_data == 16'h5555, "R6 program ok", got_data, 16'h5555);
  endtask

  task automatic t_verify_fail();
    busy_len = 0;
    do_op(3'd4, 22'h000040, 16'hAA55);
    chk(got_sts == 2'd2, "R9 verify status", got_sts, 2);
    chk(got_data == 16'h0055, "R9 readback word", got_data, 16'h0055);
  endtask

  task automatic t_timeout();
    busy_len = 100000;
    do_op(3'd2, 22'h000200, '0);
    chk(reads_n - base_r == 2 * MP, "R8 read count", reads_n - base_r, 2 * MP);
    chk(log_n - base_w == 7, "R8 write count", log_n - base_w, 7);
    chk_wr(6, 22'h000200, 16'h00F0, "R8 reset write");
    chk(got_sts == 2'd1, "R8 status", got_sts, 1);
    busy_len = 0;
  endtask

  task automatic t_bypass();
    do_op(3'd6, 22'h000080, 16'h1111);
    chk(got_sts == 2'd3 && log_n == base_w && reads_n == base_r, "R13 bypass program refused", got_sts, 3);
    do_op(3'd7, 22'h000080, '0);
    chk(got_sts == 2'd3 && log_n == base_w, "R13 exit refused", got_sts, 3);
    do_op(3'd5, 22'h000000, '0);
    chk(log_n - base_w == 3, "R10 write count", log_n - base_w, 3);
    chk_key(0, "R10 unlock");
    chk_wr(2, AW'(16'h5555), 16'h0020, "R10 bypass cmd");
    chk(bypass_on == 1'b1 && got_sts == 2'd0, "R10 mode on", bypass_on, 1);
    do_op(3'd4, 22'h000090, 16'h0000);
    chk(got_sts == 2'd3 && log_n == base_w, "R13 normal program refused", got_sts, 3);
    do_op(3'd5, 22'h000000, '0);
    chk(got_sts == 2'd3 && log_n == base_w, "R13 double enter refused", got_sts, 3);
    do_op(3'd6, 22'h000080, 16'h0123);
    chk(log_n - base_w == 2, "R11 write count", log_n - base_w, 2);
    chk_wr(0, 22'h000080, 16'h00A0, "R11 program cmd");
    chk_wr(1, 22'h000080, 16'h0123, "R11 data write");
    chk(got_sts == 2'd0 && got_data == 16'h0123 && reads_n - base_r == 3, "R11 result", got_data, 16'h0123);
    do_op(3'd7, 22'h000010, '0);
    chk(log_n - base_w == 2, "R12 write count", log_n - base_w, 2);
    chk_wr(0, 22'h000010, 16'h0090, "R12 first write");
    chk_wr(1, 22'h000010, 16'h0000, "R12 second write");
    chk(bypass_on == 1'b0 && got_sts == 2'd0, "R12 mode off", bypass_on, 0);
    do_op(3'd6, 22'h000084, 16'h2222);
    chk(got_sts == 2'd3 && log_n == base_w, "R13 refused after exit", got_sts, 3);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset_state();
    t_reset_op();
    t_read_id();
    t_sector_erase();
    t_chip_erase();
    t_program();
    t_verify_fail();
    t_timeout();
    t_bypass();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule